// File: doc/BRIEF.md
# Interrupt Destination Router

This block takes one interrupt command and works out which local interrupt units receive it. The command carries a destination byte, a bit that picks physical or logical addressing, a two-bit shorthand, a delivery mode, a vector, a trigger bit, a level bit and the index of the sending unit. Each unit supplies a presence bit, an ID byte, a logical-destination byte and a four-bit addressing model.

The block sends out a registered result one clock after the command. The result holds a per-unit delivery mask, an action code that tells the receiving units what to do, the vector and trigger bits passed through unchanged, and, for lowest-priority commands, the index of the one chosen unit. Lowest-priority arbitration picks the lowest-numbered candidate. Injecting the request into each unit is left to the logic that consumes the mask.

Top module: `intr_dest_router`

## Requirements
- R1: With physical addressing (`req_logical`=0) and shorthand 0, a destination of 0xFF selects every present unit. Any other destination selects only the lowest-indexed present unit whose ID equals it. If no present unit has that ID, the mask is empty.
- R2: With logical addressing and shorthand 0, a unit whose model nibble is 0xF (flat) is selected when the destination AND its logical byte is nonzero.
- R3: With logical addressing and shorthand 0, a unit whose model nibble is 0x0 (cluster) is selected when the upper nibbles of the destination and its logical byte are equal and their lower nibbles share a set bit. A unit with any other model nibble is never selected by logical addressing.
- R4: Shorthand 1 selects the sending unit (`req_src`) only. Shorthand 2 selects every unit. Shorthand 3 selects every unit except the sender. Shorthand 0 uses the destination field.
- R5: Delivery mode 1 (lowest priority) narrows the mask to its lowest-numbered set bit. It reports that unit on `out_lp_idx` with `out_lp_valid`=1. If no unit matches, the mask is empty and `out_lp_valid`=0.
- R6: Delivery modes map to action codes as follows. Mode 0 (fixed) and mode 7 (external) give action 1 (inject). Mode 2 gives action 3 (SMI). Mode 4 gives action 4 (NMI). Mode 5 gives action 5 (INIT). Mode 3 is reserved and gives action 0 with an empty mask. The vector and trigger inputs are passed to `out_vector` and `out_trigger`.
- R7: Mode 5 with `req_level`=0 and `req_trigger`=1 gives action 6 (copy ID into arbitration ID) instead of action 5, with the same mask.
- R8: Mode 6 (startup) gives action 7 with the command's vector on `out_vector` and the selected units in the mask.
- R9: A unit whose presence bit is 0 never appears in the mask, even under broadcast or shorthand.
- R10: The result appears one clock after a cycle with `req_valid`=1. In a clock that follows a cycle without a command, `out_valid` is 0 and the mask is empty. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present this cycle |
| req_dest | input | ID_W | Destination ID or logical byte |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| req_dmode | input | 3 | Delivery mode |
| req_vector | input | 8 | Interrupt vector |
| req_trigger | input | 1 | Trigger bit (1 = level) |
| req_level | input | 1 | Level (assert) bit |
| req_src | input | IDXW | Index of the sending unit |
| unit_present | input | N_UNITS | Presence bit per unit |
| unit_id | input | N_UNITS*ID_W | ID per unit, unit 0 in the low byte |
| unit_ldest | input | N_UNITS*ID_W | Logical-destination byte per unit |
| unit_model | input | N_UNITS*4 | Addressing-model nibble per unit |
| out_valid | output | 1 | Result valid |
| out_mask | output | N_UNITS | Units that receive the command |
| out_action | output | 3 | Action code per R6 to R8 |
| out_vector | output | 8 | Vector passed through |
| out_trigger | output | 1 | Trigger passed through |
| out_lp_valid | output | 1 | Lowest-priority unit chosen |
| out_lp_idx | output | IDXW | Index of the chosen unit |

## Verification
Every result is due in the clock after the command is sampled, because there is exactly one register between the command inputs and all outputs. The bench drives a command on a falling edge and lets one rising edge pass. It then compares the mask, action and lowest-priority outputs on the next falling edge. After that it drops `req_valid` and checks one edge later that the result has cleared.

// File: rtl/idr_pkg.sv
package idr_pkg;

    // delivery mode input codes
    localparam logic [2:0] DM_FIXED   = 3'd0;
    localparam logic [2:0] DM_LOWEST  = 3'd1;
    localparam logic [2:0] DM_SMI     = 3'd2;
    localparam logic [2:0] DM_RSVD    = 3'd3;
    localparam logic [2:0] DM_NMI     = 3'd4;
    localparam logic [2:0] DM_INIT    = 3'd5;
    localparam logic [2:0] DM_STARTUP = 3'd6;
    localparam logic [2:0] DM_EXTERN  = 3'd7;

    // shorthand codes
    localparam logic [1:0] SH_FIELD     = 2'd0;
    localparam logic [1:0] SH_SELF      = 2'd1;
    localparam logic [1:0] SH_ALL       = 2'd2;
    localparam logic [1:0] SH_ALL_OTHER = 2'd3;

    // addressing models
    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_INJECT  = 3'd1,
        ACT_LOWEST  = 3'd2,
        ACT_SMI     = 3'd3,
        ACT_NMI     = 3'd4,
        ACT_INIT    = 3'd5,
        ACT_ARBSYNC = 3'd6,
        ACT_STARTUP = 3'd7
    } action_e;

    typedef struct packed {
        action_e    action;
        logic [7:0] vector;
        logic       trigger;
    } cmd_out_t;

    function automatic action_e decode_action(input logic [2:0] dmode,
                                              input logic       level,
                                              input logic       trigger);
        action_e a;
        case (dmode)
            DM_FIXED, DM_EXTERN: a = ACT_INJECT;
            DM_LOWEST:           a = ACT_LOWEST;
            DM_SMI:              a = ACT_SMI;
            DM_NMI:              a = ACT_NMI;
            DM_INIT:             a = (!level && trigger) ? ACT_ARBSYNC : ACT_INIT;
            DM_STARTUP:          a = ACT_STARTUP;
            default:             a = ACT_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/idr_unit_match.sv
module idr_unit_match
    import idr_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            present,
    input  logic [ID_W-1:0] own_id,
    input  logic [ID_W-1:0] own_ldest,
    input  logic [3:0]      own_model,
    input  logic [ID_W-1:0] dest,
    output logic            phys_hit,
    output logic            log_hit
);
    localparam int HALF = ID_W / 2;

    logic flat_hit;
    logic cluster_hit;

    always_comb begin
        phys_hit    = present && (own_id == dest);
        flat_hit    = (own_model == MODEL_FLAT) && (|(dest & own_ldest));
        cluster_hit = (own_model == MODEL_CLUSTER)
                   && (dest[ID_W-1:HALF] == own_ldest[ID_W-1:HALF])
                   && (|(dest[HALF-1:0] & own_ldest[HALF-1:0]));
        log_hit     = present && (flat_hit || cluster_hit);
    end

    always_comb begin
        if (!present) begin
            AST_ABSENT_NO_HIT: assert (!phys_hit && !log_hit) else $error("absent unit matched"); // R9
        end
    end

endmodule

// File: rtl/idr_low_pick.sv
module idr_low_pick #(
    parameter int WIDTH = 8,
    parameter int IDXW  = 3
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDXW-1:0]  idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end

    always_comb begin
        if (found) begin
            AST_PICK_IS_SET: assert (vec[idx]) else $error("picked bit clear"); // R5
            AST_PICK_LOWEST: assert ((vec & ((WIDTH'(1) << idx) - WIDTH'(1))) == '0)
                else $error("lower bit skipped"); // R5
        end
    end

endmodule

// File: rtl/intr_dest_router.sv
module intr_dest_router
    import idr_pkg::*;
#(
    parameter int N_UNITS = 8,
    parameter int ID_W    = 8,
    localparam int IDXW   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [ID_W-1:0]         req_dest,
    input  logic                    req_logical,
    input  logic [1:0]              req_shorthand,
    input  logic [2:0]              req_dmode,
    input  logic [7:0]              req_vector,
    input  logic                    req_trigger,
    input  logic                    req_level,
    input  logic [IDXW-1:0]         req_src,
    input  logic [N_UNITS-1:0]      unit_present,
    input  logic [N_UNITS*ID_W-1:0] unit_id,
    input  logic [N_UNITS*ID_W-1:0] unit_ldest,
    input  logic [N_UNITS*4-1:0]    unit_model,
    output logic                    out_valid,
    output logic [N_UNITS-1:0]      out_mask,
    output logic [2:0]              out_action,
    output logic [7:0]              out_vector,
    output logic                    out_trigger,
    output logic                    out_lp_valid,
    output logic [IDXW-1:0]         out_lp_idx
);
    localparam logic [ID_W-1:0] BCAST = '1;

    logic [N_UNITS-1:0] phys_hits;
    logic [N_UNITS-1:0] log_hits;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        idr_unit_match #(.ID_W(ID_W)) match_i (
            .present   (unit_present[u]),
            .own_id    (unit_id[u*ID_W +: ID_W]),
            .own_ldest (unit_ldest[u*ID_W +: ID_W]),
            .own_model (unit_model[u*4 +: 4]),
            .dest      (req_dest),
            .phys_hit  (phys_hits[u]),
            .log_hit   (log_hits[u])
        );
    end

    // physical: lowest-indexed ID match only
    logic            phys_found;
    logic [IDXW-1:0] phys_idx;
    idr_low_pick #(.WIDTH(N_UNITS), .IDXW(IDXW)) phys_pick_i (
        .vec   (phys_hits),
        .found (phys_found),
        .idx   (phys_idx)
    );

    logic [N_UNITS-1:0] self_bit;
    logic [N_UNITS-1:0] phys_sel;
    logic [N_UNITS-1:0] cand_mask;
    action_e            act;

    always_comb begin
        self_bit = N_UNITS'(1) << req_src;
        if (req_dest == BCAST)
            phys_sel = unit_present;
        else if (phys_found)
            phys_sel = N_UNITS'(1) << phys_idx;
        else
            phys_sel = '0;

        case (req_shorthand)
            SH_FIELD:     cand_mask = req_logical ? log_hits : phys_sel;
            SH_SELF:      cand_mask = unit_present & self_bit;
            SH_ALL:       cand_mask = unit_present;
            default:      cand_mask = unit_present & ~self_bit;
        endcase

        act = decode_action(req_dmode, req_level, req_trigger);
    end

    // lowest-priority: first candidate wins
    logic            lp_found;
    logic [IDXW-1:0] lp_idx;
    idr_low_pick #(.WIDTH(N_UNITS), .IDXW(IDXW)) lp_pick_i (
        .vec   (cand_mask),
        .found (lp_found),
        .idx   (lp_idx)
    );

    logic [N_UNITS-1:0] final_mask;
    cmd_out_t           cmd_nxt;

    always_comb begin
        case (act)
            ACT_NONE:   final_mask = '0;
            ACT_LOWEST: final_mask = lp_found ? (N_UNITS'(1) << lp_idx) : '0;
            default:    final_mask = cand_mask;
        endcase
        cmd_nxt.action  = act;
        cmd_nxt.vector  = req_vector;
        cmd_nxt.trigger = req_trigger;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_mask     <= '0;
            out_action   <= ACT_NONE;
            out_vector   <= '0;
            out_trigger  <= 1'b0;
            out_lp_valid <= 1'b0;
            out_lp_idx   <= '0;
        end else if (req_valid) begin
            out_valid    <= 1'b1;
            out_mask     <= final_mask;
            out_action   <= cmd_nxt.action;
            out_vector   <= cmd_nxt.vector;
            out_trigger  <= cmd_nxt.trigger;
            out_lp_valid <= (act == ACT_LOWEST) && lp_found;
            out_lp_idx   <= (act == ACT_LOWEST) ? lp_idx : '0;
        end else begin
            out_valid    <= 1'b0;
            out_mask     <= '0;
            out_action   <= ACT_NONE;
            out_vector   <= '0;
            out_trigger  <= 1'b0;
            out_lp_valid <= 1'b0;
            out_lp_idx   <= '0;
        end
    end

    AST_MASK_PRESENT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_mask & ~$past(unit_present)) == '0)); // R9
    AST_LOWEST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_action == ACT_LOWEST) |-> $onehot0(out_mask)); // R5
    AST_LP_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        out_lp_valid |-> out_mask[out_lp_idx]); // R5
    AST_CMD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_mask == '0 && !out_lp_valid)); // R10
    AST_SELF_EXCLUDED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_shorthand == SH_ALL_OTHER) |=> !out_mask[$past(req_src)]); // R4
    AST_RSVD_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dmode == DM_RSVD) |=> (out_mask == '0 && out_action == ACT_NONE)); // R6

endmodule

// File: tb/intr_dest_router_tb.sv
module intr_dest_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 8;
    localparam int IDXW = 3;

    logic           clk = 1'b0;
    logic           rst;
    logic           req_valid;
    logic [7:0]     req_dest;
    logic           req_logical;
    logic [1:0]     req_shorthand;
    logic [2:0]     req_dmode;
    logic [7:0]     req_vector;
    logic           req_trigger;
    logic           req_level;
    logic [IDXW-1:0] req_src;
    logic [N-1:0]   unit_present;
    logic [N*8-1:0] unit_id;
    logic [N*8-1:0] unit_ldest;
    logic [N*4-1:0] unit_model;
    logic           out_valid;
    logic [N-1:0]   out_mask;
    logic [2:0]     out_action;
    logic [7:0]     out_vector;
    logic           out_trigger;
    logic           out_lp_valid;
    logic [IDXW-1:0] out_lp_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_dest_router #(.N_UNITS(N), .ID_W(8)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dest(req_dest),
        .req_logical(req_logical), .req_shorthand(req_shorthand),
        .req_dmode(req_dmode), .req_vector(req_vector), .req_trigger(req_trigger),
        .req_level(req_level), .req_src(req_src), .unit_present(unit_present),
        .unit_id(unit_id), .unit_ldest(unit_ldest), .unit_model(unit_model),
        .out_valid(out_valid), .out_mask(out_mask), .out_action(out_action),
        .out_vector(out_vector), .out_trigger(out_trigger),
        .out_lp_valid(out_lp_valid), .out_lp_idx(out_lp_idx)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct packed {
        logic       logical;
        logic [1:0] sh;
        logic [2:0] dmode;
        logic [7:0] dest;
        logic [2:0] src;
        logic       level;
        logic       trig;
        logic [7:0] vec;
        logic [7:0] exp_mask;
        logic [2:0] exp_act;
        logic       exp_lpv;
        logic [2:0] exp_lpi;
    } vec_t;

    // units: 0..2 flat (01,02,04), 3..5 cluster (21,22,31), 6 other model, 7 absent
    localparam int NV = 17;
    localparam vec_t TABLE [NV] = '{
        '{1'b0, 2'd0, 3'd0, 8'h12, 3'd0, 1'b1, 1'b0, 8'h30, 8'b0000_0100, 3'd1, 1'b0, 3'd0}, // R1 id match
        '{1'b0, 2'd0, 3'd0, 8'hFF, 3'd0, 1'b1, 1'b0, 8'h31, 8'b0111_1111, 3'd1, 1'b0, 3'd0}, // R1 R9 bcast
        '{1'b0, 2'd0, 3'd0, 8'h40, 3'd0, 1'b1, 1'b0, 8'h32, 8'b0000_0000, 3'd1, 1'b0, 3'd0}, // R1 none
        '{1'b1, 2'd0, 3'd0, 8'h03, 3'd0, 1'b1, 1'b0, 8'h33, 8'b0000_0011, 3'd1, 1'b0, 3'd0}, // R2 flat
        '{1'b1, 2'd0, 3'd0, 8'h21, 3'd0, 1'b1, 1'b0, 8'h34, 8'b0000_1001, 3'd1, 1'b0, 3'd0}, // R2 R3
        '{1'b1, 2'd0, 3'd0, 8'h23, 3'd0, 1'b1, 1'b0, 8'h35, 8'b0001_1011, 3'd1, 1'b0, 3'd0}, // R3 cluster
        '{1'b0, 2'd1, 3'd0, 8'h00, 3'd2, 1'b1, 1'b0, 8'h36, 8'b0000_0100, 3'd1, 1'b0, 3'd0}, // R4 self
        '{1'b0, 2'd2, 3'd0, 8'h00, 3'd2, 1'b1, 1'b0, 8'h37, 8'b0111_1111, 3'd1, 1'b0, 3'd0}, // R4 all
        '{1'b0, 2'd3, 3'd0, 8'h00, 3'd0, 1'b1, 1'b0, 8'h38, 8'b0111_1110, 3'd1, 1'b0, 3'd0}, // R4 others
        '{1'b1, 2'd0, 3'd1, 8'h23, 3'd0, 1'b1, 1'b0, 8'h39, 8'b0000_0001, 3'd2, 1'b1, 3'd0}, // R5
        '{1'b0, 2'd3, 3'd1, 8'h00, 3'd0, 1'b1, 1'b0, 8'h3A, 8'b0000_0010, 3'd2, 1'b1, 3'd1}, // R5
        '{1'b0, 2'd0, 3'd1, 8'h40, 3'd0, 1'b1, 1'b0, 8'h3B, 8'b0000_0000, 3'd2, 1'b0, 3'd0}, // R5 empty
        '{1'b0, 2'd2, 3'd4, 8'h00, 3'd0, 1'b1, 1'b0, 8'h3C, 8'b0111_1111, 3'd4, 1'b0, 3'd0}, // R6 NMI
        '{1'b0, 2'd0, 3'd5, 8'h13, 3'd0, 1'b0, 1'b1, 8'h3D, 8'b0000_1000, 3'd6, 1'b0, 3'd0}, // R7 arb
        '{1'b0, 2'd0, 3'd5, 8'h13, 3'd0, 1'b1, 1'b0, 8'h3E, 8'b0000_1000, 3'd5, 1'b0, 3'd0}, // R7 init
        '{1'b0, 2'd2, 3'd6, 8'h00, 3'd0, 1'b1, 1'b0, 8'h9A, 8'b0111_1111, 3'd7, 1'b0, 3'd0}, // R8
        '{1'b0, 2'd2, 3'd3, 8'h00, 3'd0, 1'b1, 1'b0, 8'h3F, 8'b0000_0000, 3'd0, 1'b0, 3'd0}  // R6 rsvd
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        req_valid     = 1'b1;
        req_logical   = v.logical;
        req_shorthand = v.sh;
        req_dmode     = v.dmode;
        req_dest      = v.dest;
        req_src       = v.src;
        req_level     = v.level;
        req_trigger   = v.trig;
        req_vector    = v.vec;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_logical = 1'b0; req_shorthand = 2'd0;
        req_dmode = 3'd0; req_dest = 8'h00; req_src = 3'd0;
        req_level = 1'b0; req_trigger = 1'b0; req_vector = 8'h00;
        unit_present = 8'b0111_1111;
        unit_id    = {8'h17, 8'h16, 8'h15, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10};
        unit_ldest = {8'hFF, 8'hFF, 8'h31, 8'h22, 8'h21, 8'h04, 8'h02, 8'h01};
        unit_model = {4'hF, 4'h5, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF};
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset valid", 32'(out_valid), 32'd0);
        check("R10 reset mask", 32'(out_mask), 32'd0);
        check("R10 reset lp", 32'({out_lp_valid, out_lp_idx, out_action}), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(TABLE[i]);
            check($sformatf("R10 valid vec%0d", i), 32'(out_valid), 32'd1);
            check($sformatf("R1-R9 mask vec%0d", i), 32'(out_mask), 32'(TABLE[i].exp_mask));
            check($sformatf("R6 action vec%0d", i), 32'(out_action), 32'(TABLE[i].exp_act));
            check($sformatf("R5 lowest vec%0d", i), 32'({out_lp_valid, out_lp_idx}),
                  32'({TABLE[i].exp_lpv, TABLE[i].exp_lpi}));
            check($sformatf("R8 vector vec%0d", i), 32'({out_vector, out_trigger}),
                  32'({TABLE[i].vec, TABLE[i].trig}));
        end

        // R10: idle cycle clears result
        @(negedge clk);
        check("R10 idle valid", 32'(out_valid), 32'd0);
        check("R10 idle mask", 32'(out_mask), 32'd0);

        // R1: duplicate ID -> lowest index only (unit 5 renamed to 0x12)
        unit_id[5*8 +: 8] = 8'h12;
        issue('{1'b0, 2'd0, 3'd0, 8'h12, 3'd0, 1'b1, 1'b0, 8'h50, 8'h00, 3'd0, 1'b0, 3'd0});
        check("R1 duplicate id", 32'(out_mask), 32'b0000_0100);
        unit_id[5*8 +: 8] = 8'h15;

        // R9: absent unit 7 with matching ID is not selected
        issue('{1'b0, 2'd0, 3'd0, 8'h17, 3'd0, 1'b1, 1'b0, 8'h51, 8'h00, 3'd0, 1'b0, 3'd0});
        check("R9 absent id", 32'(out_mask), 32'd0);

        // R9: absent unit excluded from logical flat match too
        issue('{1'b1, 2'd0, 3'd0, 8'h80, 3'd0, 1'b1, 1'b0, 8'h52, 8'h00, 3'd0, 1'b0, 3'd0});
        check("R9 absent logical", 32'(out_mask), 32'd0);

        // R6: external mode injects; trigger passes through
        issue('{1'b0, 2'd2, 3'd7, 8'h00, 3'd0, 1'b1, 1'b1, 8'h53, 8'h00, 3'd0, 1'b0, 3'd0});
        check("R6 external action", 32'(out_action), 32'd1);
        check("R6 trigger pass", 32'(out_trigger), 32'd1);

        // R6: SMI to self of unit 6
        issue('{1'b0, 2'd1, 3'd2, 8'h00, 3'd6, 1'b1, 1'b0, 8'h54, 8'h00, 3'd0, 1'b0, 3'd0});
        check("R6 smi", 32'({out_action, out_mask}), 32'({3'd3, 8'b0100_0000}));

        // R4: self pointing at absent unit selects nothing
        issue('{1'b0, 2'd1, 3'd0, 8'h00, 3'd7, 1'b1, 1'b0, 8'h55, 8'h00, 3'd0, 1'b0, 3'd0});
        check("R4 self absent", 32'(out_mask), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule